// File: doc/BRIEF.md
# SPI Engine Interrupt and Status Registers

This block is the register front end that a processor uses to watch an SPI command engine. It derives five interrupt sources from the engine's surroundings. Three are watermark conditions on the command queue, the outgoing data queue and the incoming data queue. The other two are single-cycle completion events from the executor, each of which carries an 8-bit identifier. The block latches the sources into a pending register, gates that register with an enable mask, and drives one interrupt line.

Software clears pending bits by writing ones to them. A watermark condition that is still true sets its bit again on the next cycle. The block also lets software read the raw source state, the last identifier captured from each completion event, and the current room and fill counts of the three queues. It also holds a software-controlled reset line for the engine. The register bus is a single-cycle write strobe with an address. Read data follows the address combinationally.

Top module: `irq_status_regs`

## Requirements
- R1: While rst_n is low, and directly after it rises, the enable mask, pending bits and both captured identifiers read as 0, the engine reset register reads 1, and irq is 0.
- R2: The source register (byte offset 0x88) shows the raw, unlatched sources in the same cycle. Bit 0 is cmd_room >= CMD_THR, bit 1 is tx_room >= TX_THR, bit 2 is rx_level >= RX_THR, bit 3 is sync_valid and bit 4 is osync_valid. Bits above 4 read 0.
- R3: A pending bit (offset 0x84, same bit layout as R2) is set on the clock edge at which its source is true, and it stays set until it is cleared.
- R4: A write to offset 0x84 clears every pending bit whose data bit is 1 and leaves bits written 0 unchanged. A source that is true in the clearing cycle keeps its bit set. Writing 0xFF clears all inactive sources.
- R5: The enable mask at offset 0x80 holds bits [4:0] of the last write there, and its upper bits read 0. Writes to other addresses do not change it.
- R6: irq is 1 exactly when some pending bit and its enable bit are both 1, evaluated on the registered state.
- R7: When sync_valid is high, sync_id is captured into offset 0xC0. When osync_valid is high, osync_id is captured into offset 0xC4. Each register holds its value otherwise.
- R8: Offsets 0xD0, 0xD4 and 0xD8 return cmd_room, tx_room and rx_level respectively, zero-extended and current in the same cycle.
- R9: Bit 0 of offset 0x40 drives engine_rst. Writing 1 asserts it, writing 0 releases it, and a read returns the held value.
- R10: Writes to read-only or unmapped offsets change no state, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for both read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr |
| cmd_room | input | CNT_W | Free entries in the command queue |
| tx_room | input | CNT_W | Free entries in the outgoing data queue |
| rx_level | input | CNT_W | Filled entries in the incoming data queue |
| sync_valid | input | 1 | Completion event pulse |
| sync_id | input | ID_W | Identifier carried by the completion event |
| osync_valid | input | 1 | Offload completion event pulse |
| osync_id | input | ID_W | Identifier carried by the offload completion event |
| irq | output | 1 | Interrupt request |
| engine_rst | output | 1 | Reset held on the SPI engine |

## Verification
A corrupted pending or enable bit appears on irq in the same cycle that the bad state is registered. A read of 0x80 or 0x84 shows it on rdata at once. A lost identifier capture or a clear that wins over an active source stays hidden until the next read of 0xC0/0xC4 or 0x84. The bench therefore reads every mapped address repeatedly and compares rdata, irq and engine_rst against a behavioural model on every cycle. This bounds the detection delay to a few cycles.

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int ID_W    = 8,
  parameter int CMD_THR = 4,
  parameter int TX_THR  = 4,
  parameter int RX_THR  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cmd_room,
  input  logic [CNT_W-1:0]  tx_room,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              sync_valid,
  input  logic [ID_W-1:0]   sync_id,
  input  logic              osync_valid,
  input  logic [ID_W-1:0]   osync_id,
  output logic              irq,
  output logic              engine_rst
);
  localparam int NSRC = 5;
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'('h84);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'('h88);
  localparam logic [ADDR_W-1:0] A_SID  = ADDR_W'('hC0);
  localparam logic [ADDR_W-1:0] A_OSID = ADDR_W'('hC4);
  localparam logic [ADDR_W-1:0] A_CMDR = ADDR_W'('hD0);
  localparam logic [ADDR_W-1:0] A_TXR  = ADDR_W'('hD4);
  localparam logic [ADDR_W-1:0] A_RXL  = ADDR_W'('hD8);

  logic [NSRC-1:0] src, en_q, pend_q, clr;
  logic [ID_W-1:0] sid_q, osid_q;
  logic            rst_q;
  logic            unused_wdata;

  assign src[0] = cmd_room >= CNT_W'(CMD_THR);
  assign src[1] = tx_room  >= CNT_W'(TX_THR);
  assign src[2] = rx_level >= CNT_W'(RX_THR);
  assign src[3] = sync_valid;
  assign src[4] = osync_valid;

  assign clr          = (wr_en && addr == A_PEND) ? wdata[NSRC-1:0] : '0;
  assign irq          = |(pend_q & en_q);
  assign engine_rst   = rst_q;
  assign unused_wdata = ^wdata[DATA_W-1:NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      en_q   <= '0;
      pend_q <= '0;
      sid_q  <= '0;
      osid_q <= '0;
    end else begin
      if (wr_en && addr == A_RST) rst_q <= wdata[0];
      if (wr_en && addr == A_EN)  en_q  <= wdata[NSRC-1:0];
      pend_q <= (pend_q & ~clr) | src;
      if (sync_valid)  sid_q  <= sync_id;
      if (osync_valid) osid_q <= osync_id;
    end
  end

  always_comb begin
    case (addr)
      A_RST:   rdata = DATA_W'(rst_q);
      A_EN:    rdata = DATA_W'(en_q);
      A_PEND:  rdata = DATA_W'(pend_q);
      A_SRC:   rdata = DATA_W'(src);
      A_SID:   rdata = DATA_W'(sid_q);
      A_OSID:  rdata = DATA_W'(osid_q);
      A_CMDR:  rdata = DATA_W'(cmd_room);
      A_TXR:   rdata = DATA_W'(tx_room);
      A_RXL:   rdata = DATA_W'(rx_level);
      default: rdata = '0;
    endcase
  end
endmodule

module irq_status_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [4:0]        src,
  input logic [4:0]        en_q,
  input logic [4:0]        pend_q,
  input logic [ID_W-1:0]   sid_q,
  input logic              sync_valid,
  input logic              irq,
  input logic              engine_rst
);
  localparam logic [ADDR_W-1:0] C_RST  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] C_EN   = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] C_PEND = ADDR_W'('h84);

  p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src != 0) |=> ((pend_q & $past(src)) == $past(src)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_PEND) |=> ((pend_q & $past(wdata[4:0] & ~src)) == 0));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == C_EN) |=> $stable(en_q));

  p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 0) |-> !irq);

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((pend_q & en_q) != 0));

  p_id_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_valid |=> $stable(sid_q));

  p_rst_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_RST) |=> (engine_rst == $past(wdata[0])));
endmodule

bind irq_status_regs irq_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .src(src), .en_q(en_q), .pend_q(pend_q), .sid_q(sid_q),
  .sync_valid(sync_valid), .irq(irq), .engine_rst(engine_rst)
);

// File: tb/tb_irq_status_regs.sv
module tb_irq_status_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  cr = 0, tr = 0, rl = 0, sid = 0, oid = 0;
  logic        sv = 0, ov = 0;
  logic        irq, engine_rst;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  irq_status_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .cmd_room(cr), .tx_room(tr), .rx_level(rl),
    .sync_valid(sv), .sync_id(sid), .osync_valid(ov), .osync_id(oid),
    .irq(irq), .engine_rst(engine_rst)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  logic [4:0] m_en, m_pend;
  logic       m_rst;
  logic [7:0] m_sid, m_oid;

  function automatic logic [4:0] exp_src();
    return {ov, sv, (rl >= 12), (tr >= 4), (cr >= 4)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_rst = 1; m_sid = 0; m_oid = 0;
    end else begin
      logic [4:0] s;
      s = exp_src();
      if (wr_en && addr == 12'h84) m_pend = m_pend & ~wdata[4:0];
      m_pend = m_pend | s;
      if (wr_en && addr == 12'h80) m_en = wdata[4:0];
      if (wr_en && addr == 12'h40) m_rst = wdata[0];
      if (sv) m_sid = sid;
      if (ov) m_oid = oid;
    end
  end

  function automatic logic [31:0] exp_rdata();
    case (addr)
      12'h40: return {31'd0, m_rst};
      12'h80: return {27'd0, m_en};
      12'h84: return {27'd0, m_pend};
      12'h88: return {27'd0, exp_src()};
      12'hC0: return {24'd0, m_sid};
      12'hC4: return {24'd0, m_oid};
      12'hD0: return {24'd0, cr};
      12'hD4: return {24'd0, tr};
      12'hD8: return {24'd0, rl};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of();
    if (!rst_n) return "R1";
    case (addr)
      12'h40: return "R9";
      12'h80: return "R5";
      12'h84: return "R3/R4";
      12'h88: return "R2";
      12'hC0, 12'hC4: return "R7";
      12'hD0, 12'hD4, 12'hD8: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    #5;
    if (!done) begin
      n_vec++;
      if (rdata !== exp_rdata()) begin
        n_bad++;
        $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag_of(), addr, rdata, exp_rdata());
      end
      n_vec++;
      if (irq !== |(m_pend & m_en)) begin
        n_bad++;
        $display("FAIL %s irq actual=%b expected=%b", rst_n ? "R6" : "R1", irq, |(m_pend & m_en));
      end
      n_vec++;
      if (engine_rst !== m_rst) begin
        n_bad++;
        $display("FAIL %s engine_rst actual=%b expected=%b", rst_n ? "R9" : "R1", engine_rst, m_rst);
      end
    end
  end

  task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [11:0] a);
    step(0, a, 0);
  endtask

  localparam logic [11:0] ALIST [10] = '{12'h40, 12'h80, 12'h84, 12'h88, 12'hC0,
                                         12'hC4, 12'hD0, 12'hD4, 12'hD8, 12'h44};

  initial begin
    // R1: reset values observed while in reset and right after
    cr = 10; rd(12'h40); rd(12'h80); rd(12'h84); rd(12'hC0);
    @(negedge clk); rst_n = 1; cr = 0;
    rd(12'h84); rd(12'h40);
    // R9: release and re-assert engine reset
    step(1, 12'h40, 0); rd(12'h40); step(1, 12'h40, 1); rd(12'h40); step(1, 12'h40, 0);
    // R2, R3: command room watermark, boundary 3/4
    cr = 3; rd(12'h88); rd(12'h84);
    cr = 4; rd(12'h88); rd(12'h84);
    // R6: enable bit0 raises irq
    step(1, 12'h80, 32'hFFFF_FFE1); rd(12'h80);
    // R4: clear while source active keeps bit
    step(1, 12'h84, 1); rd(12'h84);
    cr = 2; step(1, 12'h84, 0); rd(12'h84);
    step(1, 12'h84, 1); rd(12'h84);
    // R2/R3: tx and rx boundaries
    tr = 3; rd(12'h88); tr = 4; rd(12'h84); tr = 0;
    rl = 11; rd(12'h88); rl = 12; rd(12'h84); rl = 0;
    step(1, 12'h80, 32'h1F); rd(12'h84);
    // R4: 0xFF clears everything inactive
    step(1, 12'h84, 32'hFF); rd(12'h84);
    // R7: sync and offload sync identifier capture
    sid = 8'h5A; sv = 1; rd(12'hC0); sv = 0; sid = 8'h11; rd(12'hC0); rd(12'h84);
    oid = 8'hA5; ov = 1; rd(12'hC4); ov = 0; oid = 8'h22; rd(12'hC4); rd(12'h84);
    // R8: counts pass through
    cr = 8'd200; tr = 8'd7; rl = 8'd255; rd(12'hD0); rd(12'hD4); rd(12'hD8);
    // R10: writes to read-only/unmapped offsets are ignored
    step(1, 12'h88, 0); step(1, 12'hC0, 32'hFF); step(1, 12'hD0, 32'h3); step(1, 12'h44, 32'h1F);
    rd(12'hC0); rd(12'h44); rd(12'h80); rd(12'h40);
    step(1, 12'h84, 32'hFF); cr = 0; tr = 0; rl = 0; rd(12'h84);
    // mixed traffic against the reference
    for (int i = 0; i < 600; i++) begin
      cr = 8'($urandom_range(0, 8)); tr = 8'($urandom_range(0, 8));
      rl = 8'($urandom_range(8, 16));
      sv = ($urandom_range(0, 5) == 0); sid = 8'($urandom);
      ov = ($urandom_range(0, 5) == 0); oid = 8'($urandom);
      step(($urandom_range(0, 2) == 0), ALIST[$urandom_range(0, 9)], $urandom);
    end
    step(0, 12'h84, 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule